// File: doc/BRIEF.md
# Token-Counting Block Coherence Controller

This controller sits beside one node's cache and decides, for a small set of memory blocks, whether the local processor may read or write each block. The decision rests only on how many of the block's tokens the node holds. Every block has a fixed number of tokens system-wide. A node may write only while it holds every one of them. It may read while it holds at least one token and a valid copy of the data. This keeps the rule of one writer or many readers for every block at every moment.

Tokens move in messages, and the count is never changed by anything else. An incoming message adds its token count to the block and may carry the block's data. A request from another node makes this controller give up tokens:
- For a remote write, it gives up all of its tokens.
- For a remote read, it gives up one token, with the data, but only when it holds more than one.

A local access that lacks tokens is held off and raises a token request naming the block and the kind of access. It is granted in the first cycle after enough tokens have arrived.

Top module: `tok_coh_ctrl`

## Requirements
- R1: After reset every block holds zero tokens and no valid data, no response is issued, and any local access stalls.
- R2: A local write is granted, and its data stored, only while the block holds all TOTAL tokens. Otherwise it stalls, and the stalled write's data is not stored.
- R3: A local read is granted when the block holds at least one token and valid data. `acc_rdata` then shows the block's data in the same cycle.
- R4: A local access that lacks tokens or data drives `req_valid`=1 with `req_blk` = the accessed block and `req_write` = 1 for a write or 0 for a read. It is granted in the cycle after a message supplying the missing tokens is taken.
- R5: A message taken on `in_valid` adds `in_tok` to the block's count. When `in_has_data`=1 it also stores `in_data` and marks the data valid.
- R6: A remote write request to a block with a nonzero count produces, one cycle later, a response carrying all of the block's tokens, with `out_has_data` = the block's data valid flag. The block is then left with zero tokens and no valid data.
- R7: A remote read request produces a response of exactly one token with the data only when the block holds more than one token. With one token or none, no response is issued.
- R8: Each response lowers the block's count by exactly the `out_tok` it carries. Tokens leave only through responses.
- R9: A local access to the block named by a remote request in the same cycle stalls and does not raise `req_valid`.
- R10: Token counts and data of different blocks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Local access present |
| acc_write | input | 1 | 1 = local write, 0 = local read |
| acc_blk | input | BW | Block of the local access |
| acc_wdata | input | DW | Local write data |
| acc_grant | output | 1 | Local access permitted this cycle |
| acc_stall | output | 1 | Local access held off this cycle |
| acc_rdata | output | DW | Data of the accessed block |
| req_valid | output | 1 | Token request for a stalled access |
| req_write | output | 1 | Request needs all tokens (write) |
| req_blk | output | BW | Block the request names |
| in_valid | input | 1 | Incoming token message |
| in_blk | input | BW | Block of the incoming message |
| in_tok | input | TW | Tokens carried in |
| in_has_data | input | 1 | Incoming message carries data |
| in_data | input | DW | Incoming data |
| rreq_valid | input | 1 | Request from another node |
| rreq_write | input | 1 | Remote request wants to write |
| rreq_blk | input | BW | Block of the remote request |
| out_valid | output | 1 | Outgoing response message |
| out_blk | output | BW | Block of the response |
| out_tok | output | TW | Tokens carried out |
| out_has_data | output | 1 | Response carries data |
| out_data | output | DW | Response data |

## Verification
The permission logic is tried with a block built up from one token with data to the full set. A read is expected to pass at one token, and a write is expected to pass only at the full count. This tells the read threshold apart from the write threshold.

Remote reads are issued at counts of 4, 3, 2 and 1. Remote writes are issued with and without held data. These show the one-token rule apart from the take-everything rule, and show that the count drops by exactly what leaves.

A block holding tokens but no data, a request that collides with a local access, and an untouched neighbouring block separate the data-valid condition, the collision stall and per-block independence.

// File: rtl/tok_coh_pkg.sv
package tok_coh_pkg;

    typedef enum logic [2:0] {
        OP_MSG   = 3'd0,
        OP_RD    = 3'd1,
        OP_WR    = 3'd2,
        OP_RRD   = 3'd3,
        OP_RWR   = 3'd4
    } op_e;

    // tokens handed over for a remote request given the held count
    function automatic int unsigned give_count(input logic is_wr, input int unsigned held);
        if (is_wr)
            return held;
        else if (held > 1)
            return 1;
        else
            return 0;
    endfunction

    function automatic logic read_ok(input int unsigned held, input logic vld);
        return (held != 0) && vld;
    endfunction

    function automatic logic write_ok(input int unsigned held, input int unsigned total);
        return held == total;
    endfunction

endpackage

// File: rtl/tok_coh_store.sv
module tok_coh_store #(
    parameter int NBLK  = 8,
    parameter int TOTAL = 4,
    parameter int DW    = 16,
    localparam int BW   = $clog2(NBLK),
    localparam int TW   = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [BW-1:0] in_blk,
    input  logic [TW-1:0] in_tok,
    input  logic          in_has_data,
    input  logic [DW-1:0] in_data,
    input  logic          take_en,
    input  logic [BW-1:0] take_blk,
    input  logic [TW-1:0] take_tok,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_blk,
    input  logic [DW-1:0] wr_data,
    input  logic [BW-1:0] a_blk,
    output logic [TW-1:0] a_cnt,
    output logic          a_vld,
    output logic [DW-1:0] a_data,
    input  logic [BW-1:0] r_blk,
    output logic [TW-1:0] r_cnt,
    output logic          r_vld,
    output logic [DW-1:0] r_data
);
    logic [TW-1:0] cnt_a [NBLK];
    logic          vld_a [NBLK];
    logic [DW-1:0] dat_a [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [TW-1:0] cnt_q;
        logic          vld_q;
        logic [DW-1:0] dat_q;
        logic [TW:0]   cnt_n;
        logic          vld_n;
        logic          hit_in, hit_take, hit_wr;

        assign hit_in   = in_valid && (in_blk == BW'(b));
        assign hit_take = take_en && (take_blk == BW'(b));
        assign hit_wr   = wr_en && (wr_blk == BW'(b));

        always_comb begin
            cnt_n = {1'b0, cnt_q};
            if (hit_in)
                cnt_n = cnt_n + {1'b0, in_tok};
            if (hit_take)
                cnt_n = cnt_n - {1'b0, take_tok};
            vld_n = vld_q;
            if (hit_in && in_has_data)
                vld_n = 1'b1;
            if (cnt_n == '0)
                vld_n = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                vld_q <= 1'b0;
                dat_q <= '0;
            end else begin
                cnt_q <= cnt_n[TW-1:0];
                vld_q <= vld_n;
                if (hit_in && in_has_data)
                    dat_q <= in_data;
                if (hit_wr)
                    dat_q <= wr_data;
            end
        end

        assign cnt_a[b] = cnt_q;
        assign vld_a[b] = vld_q;
        assign dat_a[b] = dat_q;
    end

    assign a_cnt  = cnt_a[a_blk];
    assign a_vld  = vld_a[a_blk];
    assign a_data = dat_a[a_blk];
    assign r_cnt  = cnt_a[r_blk];
    assign r_vld  = vld_a[r_blk];
    assign r_data = dat_a[r_blk];
endmodule

// File: rtl/tok_coh_perm.sv
module tok_coh_perm
    import tok_coh_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int TOTAL = 4,
    localparam int BW   = $clog2(NBLK),
    localparam int TW   = $clog2(TOTAL + 1)
) (
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [BW-1:0] acc_blk,
    input  logic [TW-1:0] a_cnt,
    input  logic          a_vld,
    input  logic          rreq_valid,
    input  logic [BW-1:0] rreq_blk,
    output logic          acc_grant,
    output logic          acc_stall,
    output logic          req_valid,
    output logic          req_write,
    output logic [BW-1:0] req_blk,
    output logic          wr_en
);
    logic clash, enough;

    always_comb begin
        clash  = rreq_valid && (rreq_blk == acc_blk);
        enough = acc_write ? write_ok(int'(a_cnt), TOTAL)
                           : read_ok(int'(a_cnt), a_vld);
        acc_grant = acc_valid && enough && !clash;
        acc_stall = acc_valid && !acc_grant;
        req_valid = acc_valid && !enough && !clash;
        req_write = acc_write;
        req_blk   = acc_blk;
        wr_en     = acc_grant && acc_write;
    end
endmodule

// File: rtl/tok_coh_resp.sv
module tok_coh_resp
    import tok_coh_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int TOTAL = 4,
    parameter int DW    = 16,
    localparam int BW   = $clog2(NBLK),
    localparam int TW   = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rreq_valid,
    input  logic          rreq_write,
    input  logic [BW-1:0] rreq_blk,
    input  logic [TW-1:0] r_cnt,
    input  logic          r_vld,
    input  logic [DW-1:0] r_data,
    output logic          take_en,
    output logic [BW-1:0] take_blk,
    output logic [TW-1:0] take_tok,
    output logic          out_valid,
    output logic [BW-1:0] out_blk,
    output logic [TW-1:0] out_tok,
    output logic          out_has_data,
    output logic [DW-1:0] out_data
);
    always_comb begin
        take_tok = TW'(give_count(rreq_write, int'(r_cnt)));
        take_en  = rreq_valid && (take_tok != '0);
        take_blk = rreq_blk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_blk      <= '0;
            out_tok      <= '0;
            out_has_data <= 1'b0;
            out_data     <= '0;
        end else begin
            out_valid    <= take_en;
            out_blk      <= take_blk;
            out_tok      <= take_en ? take_tok : '0;
            out_has_data <= take_en && r_vld;
            out_data     <= (take_en && r_vld) ? r_data : '0;
        end
    end
endmodule

// File: rtl/tok_coh_ctrl.sv
module tok_coh_ctrl #(
    parameter int NBLK  = 8,
    parameter int TOTAL = 4,
    parameter int DW    = 16,
    localparam int BW   = $clog2(NBLK),
    localparam int TW   = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [BW-1:0] acc_blk,
    input  logic [DW-1:0] acc_wdata,
    output logic          acc_grant,
    output logic          acc_stall,
    output logic [DW-1:0] acc_rdata,
    output logic          req_valid,
    output logic          req_write,
    output logic [BW-1:0] req_blk,
    input  logic          in_valid,
    input  logic [BW-1:0] in_blk,
    input  logic [TW-1:0] in_tok,
    input  logic          in_has_data,
    input  logic [DW-1:0] in_data,
    input  logic          rreq_valid,
    input  logic          rreq_write,
    input  logic [BW-1:0] rreq_blk,
    output logic          out_valid,
    output logic [BW-1:0] out_blk,
    output logic [TW-1:0] out_tok,
    output logic          out_has_data,
    output logic [DW-1:0] out_data
);
    logic [TW-1:0] acc_cnt, rq_cnt, take_tok;
    logic          acc_vld, rq_vld, take_en, wr_en;
    logic [DW-1:0] rq_data;
    logic [BW-1:0] take_blk;

    tok_coh_store #(.NBLK(NBLK), .TOTAL(TOTAL), .DW(DW)) store_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_blk(in_blk), .in_tok(in_tok),
        .in_has_data(in_has_data), .in_data(in_data),
        .take_en(take_en), .take_blk(take_blk), .take_tok(take_tok),
        .wr_en(wr_en), .wr_blk(acc_blk), .wr_data(acc_wdata),
        .a_blk(acc_blk), .a_cnt(acc_cnt), .a_vld(acc_vld), .a_data(acc_rdata),
        .r_blk(rreq_blk), .r_cnt(rq_cnt), .r_vld(rq_vld), .r_data(rq_data)
    );

    tok_coh_perm #(.NBLK(NBLK), .TOTAL(TOTAL)) perm_i (
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_blk(acc_blk),
        .a_cnt(acc_cnt), .a_vld(acc_vld),
        .rreq_valid(rreq_valid), .rreq_blk(rreq_blk),
        .acc_grant(acc_grant), .acc_stall(acc_stall),
        .req_valid(req_valid), .req_write(req_write), .req_blk(req_blk),
        .wr_en(wr_en)
    );

    tok_coh_resp #(.NBLK(NBLK), .TOTAL(TOTAL), .DW(DW)) resp_i (
        .clk(clk), .rst(rst),
        .rreq_valid(rreq_valid), .rreq_write(rreq_write), .rreq_blk(rreq_blk),
        .r_cnt(rq_cnt), .r_vld(rq_vld), .r_data(rq_data),
        .take_en(take_en), .take_blk(take_blk), .take_tok(take_tok),
        .out_valid(out_valid), .out_blk(out_blk), .out_tok(out_tok),
        .out_has_data(out_has_data), .out_data(out_data)
    );
endmodule

// File: rtl/tok_coh_chk.sv
module tok_coh_chk #(
    parameter int NBLK  = 8,
    parameter int TOTAL = 4,
    localparam int BW   = $clog2(NBLK),
    localparam int TW   = $clog2(TOTAL + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [BW-1:0] acc_blk,
    input logic          acc_grant,
    input logic          acc_stall,
    input logic          req_valid,
    input logic          rreq_valid,
    input logic          rreq_write,
    input logic [BW-1:0] rreq_blk,
    input logic          out_valid,
    input logic [TW-1:0] out_tok,
    input logic [TW-1:0] acc_cnt,
    input logic          acc_vld
);
    assert_write_all_R2: assert property (@(posedge clk) disable iff (rst)
        acc_grant && acc_write |-> acc_cnt == TW'(TOTAL));

    assert_read_token_R3: assert property (@(posedge clk) disable iff (rst)
        acc_grant && !acc_write |-> (acc_cnt != '0) && acc_vld);

    assert_req_only_stalled_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> acc_stall && acc_valid);

    assert_resp_bounds_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_tok != '0) && (out_tok <= TW'(TOTAL)));

    assert_read_one_R7: assert property (@(posedge clk) disable iff (rst)
        rreq_valid && !rreq_write |=> !out_valid || out_tok == TW'(1));

    assert_clash_stall_R9: assert property (@(posedge clk) disable iff (rst)
        rreq_valid && acc_valid && (rreq_blk == acc_blk) |-> !acc_grant && !req_valid);
endmodule

bind tok_coh_ctrl tok_coh_chk #(.NBLK(NBLK), .TOTAL(TOTAL)) chk_i (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_blk(acc_blk),
    .acc_grant(acc_grant), .acc_stall(acc_stall), .req_valid(req_valid),
    .rreq_valid(rreq_valid), .rreq_write(rreq_write), .rreq_blk(rreq_blk),
    .out_valid(out_valid), .out_tok(out_tok),
    .acc_cnt(acc_cnt), .acc_vld(acc_vld)
);

// File: tb/tok_coh_ctrl_tb_top.sv
module tok_coh_ctrl_tb_top;
    import tok_coh_pkg::*;

    localparam int BW = 3;
    localparam int TW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid, acc_write;
    logic [BW-1:0] acc_blk;
    logic [DW-1:0] acc_wdata;
    logic          acc_grant, acc_stall;
    logic [DW-1:0] acc_rdata;
    logic          req_valid, req_write;
    logic [BW-1:0] req_blk;
    logic          in_valid, in_has_data;
    logic [BW-1:0] in_blk;
    logic [TW-1:0] in_tok;
    logic [DW-1:0] in_data;
    logic          rreq_valid, rreq_write;
    logic [BW-1:0] rreq_blk;
    logic          out_valid, out_has_data;
    logic [BW-1:0] out_blk;
    logic [TW-1:0] out_tok;
    logic [DW-1:0] out_data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tok_coh_ctrl dut_i (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  blk;
        logic [7:0]  tok;
        logic [15:0] data;
        logic        ea;   // grant / out_valid
        logic        eb;   // req_valid / out_has_data
        logic        ec;   // req_write / message has data
        logic [7:0]  etok;
        logic [15:0] edata;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{3'd0, 8'd2, 8'd1, 16'h1111, 1'b0, 1'b0, 1'b1, 8'd0, 16'h0},    // R5 msg with data
        '{3'd1, 8'd2, 8'd0, 16'h0,    1'b1, 1'b0, 1'b0, 8'd0, 16'h1111}, // R3 read at one token
        '{3'd2, 8'd2, 8'd0, 16'h9999, 1'b0, 1'b1, 1'b1, 8'd0, 16'h0},    // R2 write stalls
        '{3'd3, 8'd2, 8'd0, 16'h0,    1'b0, 1'b0, 1'b0, 8'd0, 16'h0},    // R7 one token kept
        '{3'd0, 8'd2, 8'd3, 16'h0,    1'b0, 1'b0, 1'b0, 8'd0, 16'h0},    // R4 tokens arrive
        '{3'd2, 8'd2, 8'd0, 16'h2222, 1'b1, 1'b0, 1'b0, 8'd0, 16'h0},    // R2 full count write
        '{3'd1, 8'd2, 8'd0, 16'h0,    1'b1, 1'b0, 1'b0, 8'd0, 16'h2222}, // R2 data stored
        '{3'd3, 8'd2, 8'd0, 16'h0,    1'b1, 1'b1, 1'b0, 8'd1, 16'h2222}, // R7 one with data
        '{3'd2, 8'd2, 8'd0, 16'h7777, 1'b0, 1'b1, 1'b1, 8'd0, 16'h0},    // R8 count now 3
        '{3'd1, 8'd2, 8'd0, 16'h0,    1'b1, 1'b0, 1'b0, 8'd0, 16'h2222}, // R2 stalled write not stored
        '{3'd4, 8'd2, 8'd0, 16'h0,    1'b1, 1'b1, 1'b0, 8'd3, 16'h2222}, // R6 give all
        '{3'd1, 8'd2, 8'd0, 16'h0,    1'b0, 1'b1, 1'b0, 8'd0, 16'h0},    // R6 left empty
        '{3'd0, 8'd5, 8'd2, 16'h0,    1'b0, 1'b0, 1'b0, 8'd0, 16'h0},    // R5 tokens only
        '{3'd1, 8'd5, 8'd0, 16'h0,    1'b0, 1'b1, 1'b0, 8'd0, 16'h0},    // R3 no data, no read
        '{3'd4, 8'd5, 8'd0, 16'h0,    1'b1, 1'b0, 1'b0, 8'd2, 16'h0},    // R6 tokens without data
        '{3'd3, 8'd0, 8'd0, 16'h0,    1'b0, 1'b0, 1'b0, 8'd0, 16'h0}     // R7 empty block
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_blk = '0; acc_wdata = '0;
        in_valid = 0; in_blk = '0; in_tok = '0; in_has_data = 0; in_data = '0;
        rreq_valid = 0; rreq_write = 0; rreq_blk = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_msg(input int b, input int t, input logic hd, input logic [15:0] d);
        in_valid = 1; in_blk = BW'(b); in_tok = TW'(t); in_has_data = hd; in_data = d;
        tick();
        idle();
    endtask

    task automatic remote(input int b, input logic wr);
        rreq_valid = 1; rreq_write = wr; rreq_blk = BW'(b);
        tick();
        idle();
    endtask

    initial begin : watchdog
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int resp_cnt;
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 0);
        acc_valid = 1; acc_blk = 3'd0;
        #1;
        check("R1 read stalls", 32'(acc_stall), 1);
        check("R1 req raised", 32'(req_valid), 1);
        tick();
        idle();

        foreach (VEC[i]) begin
            vec_t v = VEC[i];
            case (v.op)
                3'd0: begin
                    in_valid = 1; in_blk = v.blk[BW-1:0]; in_tok = v.tok[TW-1:0];
                    in_has_data = v.ec; in_data = v.data;
                end
                3'd1, 3'd2: begin
                    acc_valid = 1; acc_write = (v.op == 3'd2);
                    acc_blk = v.blk[BW-1:0]; acc_wdata = v.data;
                end
                default: begin
                    rreq_valid = 1; rreq_write = (v.op == 3'd4); rreq_blk = v.blk[BW-1:0];
                end
            endcase
            #1;
            if (v.op == 3'd1 || v.op == 3'd2) begin
                check($sformatf("R2/R3/R4 vec%0d grant", i), 32'(acc_grant), 32'(v.ea));
                check($sformatf("R4 vec%0d stall", i), 32'(acc_stall), 32'(!v.ea));
                check($sformatf("R4 vec%0d req_valid", i), 32'(req_valid), 32'(v.eb));
                if (v.eb) begin
                    check($sformatf("R4 vec%0d req_write", i), 32'(req_write), 32'(v.ec));
                    check($sformatf("R4 vec%0d req_blk", i), 32'(req_blk), 32'(v.blk));
                end
                if (v.ea && v.op == 3'd1)
                    check($sformatf("R3 vec%0d rdata", i), 32'(acc_rdata), 32'(v.edata));
            end
            tick();
            idle();
            if (v.op >= 3'd3) begin
                check($sformatf("R6/R7 vec%0d out_valid", i), 32'(out_valid), 32'(v.ea));
                if (v.ea) begin
                    check($sformatf("R6/R7 vec%0d out_tok", i), 32'(out_tok), 32'(v.etok));
                    check($sformatf("R6/R7 vec%0d out_blk", i), 32'(out_blk), 32'(v.blk));
                    check($sformatf("R6 vec%0d has_data", i), 32'(out_has_data), 32'(v.eb));
                    if (v.eb)
                        check($sformatf("R6 vec%0d out_data", i), 32'(out_data), 32'(v.edata));
                end
            end
        end

        // R8: drain a full block by remote reads, count the tokens leaving
        send_msg(1, 4, 1'b1, 16'hABCD);
        resp_cnt = 0;
        for (int k = 0; k < 4; k++) begin
            remote(1, 1'b0);
            if (out_valid) resp_cnt += int'(out_tok);
        end
        check("R8 tokens given by reads", 32'(resp_cnt), 3);
        acc_valid = 1; acc_blk = 3'd1;
        #1;
        check("R8 one token left, read ok", 32'(acc_grant), 1);
        check("R8 read data kept", 32'(acc_rdata), 32'hABCD);
        tick();
        idle();

        // R9: clash between local read and remote request
        acc_valid = 1; acc_blk = 3'd1; rreq_valid = 1; rreq_blk = 3'd1;
        #1;
        check("R9 clash stalls", 32'(acc_stall), 1);
        check("R9 clash no request", 32'(req_valid), 0);
        tick();
        idle();
        check("R9 no response at one token", 32'(out_valid), 0);

        // R10: neighbour block untouched
        acc_valid = 1; acc_blk = 3'd6;
        #1;
        check("R10 other block stalls", 32'(acc_grant), 0);
        tick();
        idle();

        // R4: stalled write granted once tokens complete
        acc_valid = 1; acc_write = 1; acc_blk = 3'd1; acc_wdata = 16'h5555;
        in_valid = 1; in_blk = 3'd1; in_tok = 3'd3;
        #1;
        check("R4 write stalls before tokens", 32'(acc_grant), 0);
        tick();
        in_valid = 0; in_tok = '0;
        #1;
        check("R4 write granted after tokens", 32'(acc_grant), 1);
        tick();
        idle();

        // R1: mid-run reset clears tokens
        rst = 1;
        tick();
        rst = 0;
        acc_valid = 1; acc_blk = 3'd1;
        #1;
        check("R1 tokens cleared by reset", 32'(acc_grant), 0);
        tick();
        idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule